// File: doc/BRIEF.md
# Receive Address Filter and Buffer Controller

This block sits behind a word-wide receive interface and decides, packet by packet, whether incoming traffic belongs to this station. The first word of each packet carries the destination host number in its upper byte; the block compares it against the local host number and either accepts the packet or discards it up to its end. An accepted packet is written word by word into a buffer through a plain write port, starting at a programmed base address. Once a packet is accepted, the block also sends a one-cycle pulse that tells the transmitter to abandon any retransmission wait it is in.

Each received word is held for one arrival before it is written. Because of this one-word lag, the trailing check word (CRC) is stored but not counted. It also lets the block tell a buffer that was filled exactly, where the next word is the CRC and then the end status, from a true overflow. On completion the block posts a completion code, the masked end status and a 16-bit ending word count in registers, marks them with a one-cycle pulse, and switches the receiver off. A new arm request switches it back on.

Top module: `rx_filter_buf`

## Requirements
- R1: After reset, rx_on, wr_en, tx_reset and post_valid are 0, and post_code, post_status and post_count are 0.
- R2: The destination is rx_data[15:8] of a packet's first word. The packet is accepted when the destination is 0, when it equals local_addr, or when local_addr is 0.
- R3: A packet that is not accepted causes no write and no post. Its words are skipped up to and including the word flagged by rx_atten, and the receiver stays on for the next packet.
- R4: Accepting a packet raises tx_reset for exactly one cycle, the cycle after its first word arrives. A zero-length packet does not raise it.
- R5: If word_cnt is 0 when a packet is accepted, the block posts code 3 (count zero) with status 0 and count 0, and writes nothing.
- R6: Word k of an accepted packet is written to buf_base+k. The write strobe is high in the cycle after the next word arrives, so consecutive writes use consecutive addresses.
- R7: When the end status arrives (rx_atten=1) before the buffer is full, the pending CRC word is written in that same cycle. The block then posts code 1, status = rx_data AND 16'h00FF, and count = the number of words written excluding the CRC.
- R8: If exactly word_cnt words have been written and the next word is followed directly by the end status, that next word is discarded unwritten. The block posts code 1 with the masked status and count = word_cnt.
- R9: If exactly word_cnt words have been written, a further word has arrived, and the word after that is not flagged, the block posts code 2 (overflow) with status 0 and count = word_cnt, and writes nothing more.
- R10: If the first word after arming already carries rx_atten, the block posts code 1 with the masked status and count = word_cnt.
- R11: post_valid lasts exactly one cycle, and rx_on is 0 from that cycle onward. Words arriving while rx_on is 0 are ignored. rx_arm while off sets rx_on in the next cycle. The post fields hold their values until the next post.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_arm | input | 1 | Turn the receiver on when it is off |
| rx_valid | input | 1 | A received word is present this cycle |
| rx_data | input | 16 | Received word |
| rx_atten | input | 1 | The present word is the end-of-packet status |
| local_addr | input | 8 | Local host number, 0 selects promiscuous mode |
| buf_base | input | 16 | Buffer start address, sampled at acceptance |
| word_cnt | input | 16 | Buffer size in words, sampled at acceptance |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | 16 | Buffer write address |
| wr_data | output | 16 | Buffer write data |
| tx_reset | output | 1 | One-cycle pulse that cancels the transmitter's wait |
| rx_on | output | 1 | Receiver enabled |
| post_valid | output | 1 | One-cycle completion pulse |
| post_code | output | 2 | 1 done, 2 overflow, 3 count zero |
| post_status | output | 16 | Masked end status |
| post_count | output | 16 | Ending word count |

## Verification
The assertions assume that rx_atten is meaningful only when rx_valid is high. They also assume that every packet ends with exactly one flagged status word, and that no write can come from the previous packet in the cycle after a post. This holds because a new packet needs a fresh arm first. The stimulus only asserts rx_atten together with rx_valid, and it always ends packets with a status word. It rearms only after a post has been seen, and it changes buf_base, word_cnt and local_addr only while no packet is in progress.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_IDLE,
    ST_FILL,
    ST_FULL,
    ST_SKIP
  } rxf_state_e;

  typedef enum logic [1:0] {
    PC_NONE       = 2'd0,
    PC_DONE       = 2'd1,
    PC_OVERFLOW   = 2'd2,
    PC_COUNT_ZERO = 2'd3
  } post_code_e;

endpackage

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter #(
  parameter int DW = 16,
  parameter int HW = 8
) (
  input  logic [DW-1:0] word_i,
  input  logic [HW-1:0] local_i,
  output logic          accept_o
);

  logic [HW-1:0] dest;
  logic          is_bcast;
  logic          is_mine;
  logic          is_promisc;

  always_comb begin
    dest       = word_i[DW-1 -: HW];
    is_bcast   = (dest == '0);
    is_mine    = (dest == local_i);
    is_promisc = (local_i == '0);
    accept_o   = is_bcast | is_mine | is_promisc;
  end

endmodule

// File: rtl/rxf_store_path.sv
module rxf_store_path #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic          flush_i,
  input  logic [DW-1:0] word_i,
  input  logic [AW-1:0] base_i,
  output logic [CW-1:0] stored_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);

  logic [DW-1:0] pend_q, pend_d;
  logic [CW-1:0] ptr_q, ptr_d;
  logic [AW-1:0] base_q, base_d;
  logic          wen_q, wen_d;
  logic [AW-1:0] wad_q, wad_d;
  logic [DW-1:0] wdt_q, wdt_d;
  logic          pend_en, ptr_en, base_en, wdat_en;
  logic          do_store;

  always_comb begin
    do_store = adv_i | flush_i;
    pend_d   = word_i;
    pend_en  = load_i | adv_i;
    base_d   = base_i;
    base_en  = load_i;
    ptr_en   = load_i | do_store;
    ptr_d    = load_i ? '0 : ptr_q + 1'b1;
    wen_d    = do_store;
    wdat_en  = do_store;
    wad_d    = base_q + AW'(ptr_q);
    wdt_d    = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ptr_q  <= '0;
      base_q <= '0;
      wen_q  <= 1'b0;
      wad_q  <= '0;
      wdt_q  <= '0;
    end else begin
      wen_q <= wen_d;
      if (pend_en) pend_q <= pend_d;
      if (ptr_en)  ptr_q  <= ptr_d;
      if (base_en) base_q <= base_d;
      if (wdat_en) begin
        wad_q <= wad_d;
        wdt_q <= wdt_d;
      end
    end
  end

  assign stored_o  = ptr_q;
  assign wr_en_o   = wen_q;
  assign wr_addr_o = wad_q;
  assign wr_data_o = wdt_q;

endmodule

// File: rtl/rxf_post_regs.sv
module rxf_post_regs #(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire_i,
  input  rxf_pkg::post_code_e code_i,
  input  logic [DW-1:0]      status_i,
  input  logic [CW-1:0]      count_i,
  output logic               valid_o,
  output logic [1:0]         code_o,
  output logic [DW-1:0]      status_o,
  output logic [CW-1:0]      count_o
);

  logic          valid_q;
  logic [1:0]    code_q;
  logic [DW-1:0] status_q;
  logic [CW-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      code_q   <= '0;
      status_q <= '0;
      count_q  <= '0;
    end else begin
      valid_q <= fire_i;
      if (fire_i) begin
        code_q   <= code_i;
        status_q <= status_i;
        count_q  <= count_i;
      end
    end
  end

  assign valid_o  = valid_q;
  assign code_o   = code_q;
  assign status_o = status_q;
  assign count_o  = count_q;

endmodule

// File: rtl/rx_filter_buf.sv
module rx_filter_buf #(
  parameter int            DW        = 16,
  parameter int            HW        = 8,
  parameter int            AW        = 16,
  parameter int            CW        = 16,
  parameter logic [DW-1:0] STAT_MASK = 16'h00FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_arm,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_atten,
  input  logic [HW-1:0] local_addr,
  input  logic [AW-1:0] buf_base,
  input  logic [CW-1:0] word_cnt,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          tx_reset,
  output logic          rx_on,
  output logic          post_valid,
  output logic [1:0]    post_code,
  output logic [DW-1:0] post_status,
  output logic [CW-1:0] post_count
);

  import rxf_pkg::*;

  rxf_state_e    st_q, st_d;
  logic [CW-1:0] left_q, left_d;
  logic [CW-1:0] size_q, size_d;
  logic          txr_q, txr_d;
  logic          cnt_en;

  logic          accept;
  logic          load, adv, flush;
  logic [CW-1:0] stored;
  logic          fire;
  post_code_e    code;
  logic [DW-1:0] stat;
  logic [CW-1:0] pcount;
  logic [DW-1:0] masked;

  rxf_addr_filter #(.DW(DW), .HW(HW)) filt_i (
    .word_i   (rx_data),
    .local_i  (local_addr),
    .accept_o (accept)
  );

  rxf_store_path #(.DW(DW), .AW(AW), .CW(CW)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .adv_i     (adv),
    .flush_i   (flush),
    .word_i    (rx_data),
    .base_i    (buf_base),
    .stored_o  (stored),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  rxf_post_regs #(.DW(DW), .CW(CW)) post_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_i   (fire),
    .code_i   (code),
    .status_i (stat),
    .count_i  (pcount),
    .valid_o  (post_valid),
    .code_o   (post_code),
    .status_o (post_status),
    .count_o  (post_count)
  );

  assign masked = rx_data & STAT_MASK;

  // Next-state and control decode
  always_comb begin
    st_d   = st_q;
    left_d = left_q;
    size_d = size_q;
    cnt_en = 1'b0;
    txr_d  = 1'b0;
    load   = 1'b0;
    adv    = 1'b0;
    flush  = 1'b0;
    fire   = 1'b0;
    code   = PC_NONE;
    stat   = '0;
    pcount = '0;
    unique case (st_q)
      ST_OFF: begin
        if (rx_arm) st_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (rx_valid) begin
          if (rx_atten) begin
            fire   = 1'b1;
            code   = PC_DONE;
            stat   = masked;
            pcount = word_cnt;
            st_d   = ST_OFF;
          end else if (accept) begin
            txr_d = 1'b1;
            if (word_cnt == '0) begin
              fire   = 1'b1;
              code   = PC_COUNT_ZERO;
              st_d   = ST_OFF;
            end else begin
              load   = 1'b1;
              cnt_en = 1'b1;
              left_d = word_cnt;
              size_d = word_cnt;
              st_d   = ST_FILL;
            end
          end else begin
            st_d = ST_SKIP;
          end
        end
      end
      ST_FILL: begin
        if (rx_valid) begin
          if (rx_atten) begin
            flush  = 1'b1;
            fire   = 1'b1;
            code   = PC_DONE;
            stat   = masked;
            pcount = stored;
            st_d   = ST_OFF;
          end else begin
            adv    = 1'b1;
            cnt_en = 1'b1;
            left_d = left_q - 1'b1;
            if (left_q == CW'(1)) st_d = ST_FULL;
          end
        end
      end
      ST_FULL: begin
        if (rx_valid) begin
          fire   = 1'b1;
          pcount = size_q;
          st_d   = ST_OFF;
          if (rx_atten) begin
            code = PC_DONE;
            stat = masked;
          end else begin
            code = PC_OVERFLOW;
          end
        end
      end
      ST_SKIP: begin
        if (rx_valid && rx_atten) st_d = ST_IDLE;
      end
      default: st_d = ST_OFF;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      left_q <= '0;
      size_q <= '0;
      txr_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      txr_q <= txr_d;
      if (cnt_en) begin
        left_q <= left_d;
        size_q <= size_d;
      end
    end
  end

  assign tx_reset = txr_q;
  assign rx_on    = (st_q != ST_OFF);

endmodule

// File: rtl/rx_filter_buf_chk.sv
module rx_filter_buf_chk #(
  parameter int            DW        = 16,
  parameter int            AW        = 16,
  parameter logic [DW-1:0] STAT_MASK = 16'h00FF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          tx_reset,
  input logic          rx_on,
  input logic          post_valid,
  input logic [1:0]    post_code,
  input logic [DW-1:0] post_status
);

  assert_tx_reset_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reset |=> !tx_reset);

  assert_post_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    post_valid |=> !post_valid);

  assert_off_at_post_R11: assert property (@(posedge clk) disable iff (!rst_n)
    post_valid |-> !rx_on);

  assert_count_zero_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && post_code == 2'd3) |-> (!wr_en && post_status == '0));

  assert_overflow_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && post_code == 2'd2) |-> (!wr_en && post_status == '0));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1));

  assert_write_needs_rx_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rx_on));

  assert_status_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    post_valid |-> ((post_status & ~STAT_MASK) == '0));

endmodule

bind rx_filter_buf rx_filter_buf_chk #(
  .DW(DW), .AW(AW), .STAT_MASK(STAT_MASK)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .tx_reset    (tx_reset),
  .rx_on       (rx_on),
  .post_valid  (post_valid),
  .post_code   (post_code),
  .post_status (post_status)
);

// File: tb/rx_filter_buf_tb_top.sv
module rx_filter_buf_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        rx_arm;
  logic        rx_valid;
  logic [15:0] rx_data;
  logic        rx_atten;
  logic [7:0]  local_addr;
  logic [15:0] buf_base;
  logic [15:0] word_cnt;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [15:0] wr_data;
  logic        tx_reset;
  logic        rx_on;
  logic        post_valid;
  logic [1:0]  post_code;
  logic [15:0] post_status;
  logic [15:0] post_count;

  int n_checks = 0;
  int n_fails  = 0;
  bit running  = 0;

  rx_filter_buf dut_i (
    .clk(clk), .rst_n(rst_n), .rx_arm(rx_arm), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_atten(rx_atten), .local_addr(local_addr),
    .buf_base(buf_base), .word_cnt(word_cnt), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .tx_reset(tx_reset),
    .rx_on(rx_on), .post_valid(post_valid), .post_code(post_code),
    .post_status(post_status), .post_count(post_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model: 0 off, 1 waiting, 2 storing, 3 full, 4 skipping
  int mode, m_left, m_size, m_n;
  int m_pend, m_base;
  int e_wr, e_addr, e_data, e_post, e_code, e_stat, e_cnt, e_txr, e_on;

  always @(posedge clk) begin
    e_wr = 0; e_post = 0; e_txr = 0;
    if (!rst_n) begin
      mode = 0; e_code = 0; e_stat = 0; e_cnt = 0; e_addr = 0; e_data = 0;
      m_left = 0; m_size = 0; m_n = 0; m_pend = 0; m_base = 0;
    end else if (rx_valid || mode == 0) begin
      case (mode)
        0: if (rx_arm) mode = 1;
        1: begin
          if (rx_atten) begin
            e_post = 1; e_code = 1; e_stat = rx_data & 16'h00FF; e_cnt = word_cnt; mode = 0;
          end else if (rx_data[15:8] == 0 || rx_data[15:8] == local_addr || local_addr == 0) begin
            e_txr = 1;
            if (word_cnt == 0) begin
              e_post = 1; e_code = 3; e_stat = 0; e_cnt = 0; mode = 0;
            end else begin
              m_pend = rx_data; m_base = buf_base; m_n = 0;
              m_left = word_cnt; m_size = word_cnt; mode = 2;
            end
          end else mode = 4;
        end
        2: begin
          e_wr = 1; e_addr = (m_base + m_n) % 65536; e_data = m_pend;
          if (rx_atten) begin
            e_post = 1; e_code = 1; e_stat = rx_data & 16'h00FF; e_cnt = m_n; mode = 0;
          end else begin
            m_n++; m_pend = rx_data; m_left--;
            if (m_left == 0) mode = 3;
          end
        end
        3: begin
          e_post = 1; e_cnt = m_size; mode = 0;
          if (rx_atten) begin e_code = 1; e_stat = rx_data & 16'h00FF; end
          else begin e_code = 2; e_stat = 0; end
        end
        default: if (rx_atten) mode = 1;
      endcase
    end
    e_on = (mode != 0);
  end

  always @(negedge clk) begin
    if (running) begin
      chk("R6 wr_en", 32'(wr_en), e_wr);
      if (e_wr == 1) begin
        chk("R6 wr_addr", 32'(wr_addr), e_addr);
        chk("R6 wr_data", 32'(wr_data), e_data);
      end
      chk("R4 tx_reset", 32'(tx_reset), e_txr);
      chk("R11 rx_on", 32'(rx_on), e_on);
      chk("R11 post_valid", 32'(post_valid), e_post);
      chk("R7 post_code", 32'(post_code), e_code);
      chk("R7 post_status", 32'(post_status), e_stat);
      chk("R7 post_count", 32'(post_count), e_cnt);
    end
  end

  task automatic put(input logic [15:0] w, input logic at);
    rx_valid = 1'b1; rx_data = w; rx_atten = at;
    @(negedge clk);
    rx_valid = 1'b0; rx_atten = 1'b0;
  endtask

  task automatic arm();
    rx_arm = 1'b1;
    @(negedge clk);
    rx_arm = 1'b0;
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rx_arm = 1'b0; rx_valid = 1'b0; rx_data = '0; rx_atten = 1'b0;
    local_addr = 8'h12; buf_base = 16'h0100; word_cnt = 16'd8;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rx_on", 32'(rx_on), 0);
    chk("R1 wr_en", 32'(wr_en), 0);
    chk("R1 post_valid", 32'(post_valid), 0);
    chk("R1 tx_reset", 32'(tx_reset), 0);
    chk("R1 post_count", 32'(post_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    running = 1;

    // R11: words while off are ignored
    put(16'h1234, 1'b0);
    chk("R11 ignored while off", 32'(wr_en | tx_reset | post_valid), 0);
    arm();
    chk("R11 rx_on after arm", 32'(rx_on), 1);

    // R2 exact match, R4, R6, R7 normal end
    put(16'h1234, 1'b0);
    chk("R4 tx_reset pulse", 32'(tx_reset), 1);
    put(16'h5555, 1'b0);
    chk("R6 first write addr", 32'(wr_addr), 32'h0100);
    chk("R4 tx_reset single", 32'(tx_reset), 0);
    put(16'h6666, 1'b0);
    put(16'h7777, 1'b0);
    put(16'hABCD, 1'b1);
    chk("R7 crc written", 32'(wr_data), 32'h7777);
    chk("R7 code", 32'(post_code), 1);
    chk("R7 status", 32'(post_status), 32'h00CD);
    chk("R7 count", 32'(post_count), 3);
    chk("R11 off at post", 32'(rx_on), 0);
    repeat (2) @(negedge clk);
    chk("R11 fields held", 32'(post_count), 3);

    // R2 broadcast
    buf_base = 16'h0200;
    arm();
    put(16'h00AA, 1'b0);
    chk("R2 broadcast accepted", 32'(tx_reset), 1);
    put(16'h1111, 1'b0);
    put(16'h2222, 1'b0);
    put(16'h0F0F, 1'b1);
    chk("R2 broadcast count", 32'(post_count), 2);

    // R2 promiscuous
    local_addr = 8'h00;
    arm();
    put(16'h5501, 1'b0);
    chk("R2 promiscuous accepted", 32'(tx_reset), 1);
    put(16'h3333, 1'b0);
    put(16'h0001, 1'b1);
    chk("R2 promiscuous code", 32'(post_code), 1);

    // R3 reject, then accept within the same arming
    local_addr = 8'h12;
    buf_base = 16'h0300;
    arm();
    put(16'h3400, 1'b0);
    chk("R3 no tx_reset", 32'(tx_reset), 0);
    put(16'h0101, 1'b0);
    chk("R3 no write", 32'(wr_en), 0);
    put(16'h0202, 1'b0);
    put(16'h00FF, 1'b1);
    chk("R3 no post", 32'(post_valid), 0);
    chk("R3 still on", 32'(rx_on), 1);
    put(16'h1200, 1'b0);
    chk("R3 next packet accepted", 32'(tx_reset), 1);
    put(16'h4444, 1'b0);
    put(16'h0011, 1'b1);
    chk("R3 next packet count", 32'(post_count), 1);

    // R8 exact fit
    word_cnt = 16'd2;
    buf_base = 16'h0400;
    arm();
    put(16'h1200, 1'b0);
    put(16'h2222, 1'b0);
    put(16'h3333, 1'b0);
    chk("R8 second write addr", 32'(wr_addr), 32'h0401);
    put(16'h00F0, 1'b1);
    chk("R8 crc not written", 32'(wr_en), 0);
    chk("R8 code", 32'(post_code), 1);
    chk("R8 count", 32'(post_count), 2);
    chk("R8 status", 32'(post_status), 32'h00F0);

    // R9 overflow
    arm();
    put(16'h1200, 1'b0);
    put(16'hAAAA, 1'b0);
    put(16'hBBBB, 1'b0);
    put(16'hCCCC, 1'b0);
    chk("R9 code", 32'(post_code), 2);
    chk("R9 count", 32'(post_count), 2);
    chk("R9 status", 32'(post_status), 0);
    chk("R9 no write", 32'(wr_en), 0);
    put(16'hDDDD, 1'b0);
    put(16'h0077, 1'b1);
    chk("R11 rest ignored", 32'(wr_en | post_valid), 0);

    // R5 count zero
    word_cnt = 16'd0;
    arm();
    put(16'h1200, 1'b0);
    chk("R5 code", 32'(post_code), 3);
    chk("R5 count", 32'(post_count), 0);
    chk("R5 no write", 32'(wr_en), 0);
    put(16'h0033, 1'b1);

    // R10 zero-length packet
    word_cnt = 16'd5;
    arm();
    put(16'h1234, 1'b1);
    chk("R10 code", 32'(post_code), 1);
    chk("R10 status", 32'(post_status), 32'h0034);
    chk("R10 count", 32'(post_count), 5);
    chk("R10 no tx_reset", 32'(tx_reset), 0);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule